// File: doc/BRIEF.md
# Register ALU with Flag Register

This block carries out the register-to-register arithmetic and logic group of a small 8-bit virtual machine. It owns a file of sixteen 8-bit general registers. The highest register, index 15, also serves as the flag register. Each enabled operation takes a 4-bit sub-opcode and two register indices, x and y. It reads both registers, writes the result back into register x, and updates register 15 in the way that operation defines.

Register 15 can be an operand or the destination, so the order of the two writes matters. For addition and both shifts the flag is written last, so the flag value survives when x is 15. For both subtractions the flag is written first, so the arithmetic result survives when x is 15. A sub-opcode outside the defined group is illegal. It sets a sticky error output and changes no register.

A debug write port loads register values while no operation is in progress. A combinational debug read port lets any register be observed. Each operation is registered on the enabling clock edge, and a one-cycle done strobe follows.

Top module: `alu8_vm_alu`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers, the done strobe and the error output to zero.
- R2: Sub-opcodes 0 (copy Vy), 1 (OR), 2 (AND) and 3 (XOR) write their result to Vx and leave register 15 unchanged unless x is 15.
- R3: Sub-opcode 4 writes (Vx + Vy) mod 256 to Vx and sets register 15 to the carry out (value 0 or 1). When x is 15, register 15 ends up holding the carry.
- R4: Sub-opcode 5 writes (Vx - Vy) mod 256 to Vx. Register 15 becomes 1 only when Vx > Vy, so equal operands give 0. When x is 15, register 15 ends up holding the difference.
- R5: Sub-opcode 7 writes (Vy - Vx) mod 256 to Vx. Register 15 becomes 1 only when Vy > Vx. When x is 15, register 15 ends up holding the difference.
- R6: Sub-opcode 6 shifts Vx right by one and puts the old bit 0 in register 15. Sub-opcode 14 (hex E) shifts Vx left by one and puts the old bit 7 in register 15. Vy has no effect on either shift. When x is 15, register 15 ends up holding the shifted-out bit.
- R7: Sub-opcodes 8 to 13 and 15 are illegal. An enabled illegal sub-opcode sets the error output, which stays set until reset, and leaves every register unchanged.
- R8: An operation takes effect on the clock edge where op_en is high. done is high for exactly the following cycle and is never high without a preceding enable.
- R9: A debug write (wr_en) loads wr_data into register wr_idx on the clock edge, but only when op_en is low. A debug write in a cycle with op_en high is ignored. rd_data always shows register rd_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Execute one operation on this edge |
| op_code | input | 4 | Sub-opcode |
| idx_x | input | 4 | Destination and first operand index |
| idx_y | input | 4 | Second operand index |
| wr_en | input | 1 | Debug register write enable |
| wr_idx | input | 4 | Debug write index |
| wr_data | input | 8 | Debug write data |
| rd_idx | input | 4 | Debug read index |
| rd_data | output | 8 | Debug read data (combinational) |
| done | output | 1 | One-cycle strobe after each enabled operation |
| err | output | 1 | Sticky illegal-sub-opcode indicator |

## Verification
The register result, the flag register, the error output and the done strobe all update on the same clock edge that samples op_en. All four are visible one cycle after the stimulus. The bench applies each operation at a falling edge, so the edge that executes it is the next rising edge. The monitor pops the expected register, flag and error values at the falling edge where done is high and reads them back through the debug read port within that half cycle. At the falling edge after that, the driver confirms that done has dropped again.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_MOVE = 4'h0,
        OP_OR   = 4'h1,
        OP_AND  = 4'h2,
        OP_XOR  = 4'h3,
        OP_ADD  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SHR  = 4'h6,
        OP_RSUB = 4'h7,
        OP_SHL  = 4'hE
    } alu_op_e;

    // Which of the two writes lands last when both target the flag register
    typedef enum logic {
        FLAG_FIRST = 1'b0,
        FLAG_LAST  = 1'b1
    } wr_order_e;

    typedef struct packed {
        logic      res_we;
        logic      flag_we;
        wr_order_e order;
        logic      illegal;
    } alu_ctl_t;

    function automatic logic op_is_legal(logic [OPC_W-1:0] code);
        logic ok;
        case (code)
            OP_MOVE, OP_OR, OP_AND, OP_XOR,
            OP_ADD, OP_SUB, OP_SHR, OP_RSUB, OP_SHL: ok = 1'b1;
            default:                                 ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic alu_ctl_t ctl_for(logic [OPC_W-1:0] code);
        alu_ctl_t c;
        c.res_we  = 1'b0;
        c.flag_we = 1'b0;
        c.order   = FLAG_LAST;
        c.illegal = 1'b0;
        case (code)
            OP_MOVE, OP_OR, OP_AND, OP_XOR: begin
                c.res_we = 1'b1;
            end
            OP_ADD, OP_SHR, OP_SHL: begin
                c.res_we  = 1'b1;
                c.flag_we = 1'b1;
                c.order   = FLAG_LAST;
            end
            OP_SUB, OP_RSUB: begin
                c.res_we  = 1'b1;
                c.flag_we = 1'b1;
                c.order   = FLAG_FIRST;
            end
            default: begin
                c.illegal = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu8_exec.sv
`timescale 1ns/1ps
module alu8_exec
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic              flag_bit,
    output alu_ctl_t          ctl
);

    logic [DATA_W:0] sum_ext;

    assign sum_ext = {1'b0, opa} + {1'b0, opb};
    assign ctl     = ctl_for(op_code);

    always_comb begin
        result   = '0;
        flag_bit = 1'b0;
        case (op_code)
            OP_MOVE: result = opb;
            OP_OR:   result = opa | opb;
            OP_AND:  result = opa & opb;
            OP_XOR:  result = opa ^ opb;
            OP_ADD: begin
                result   = sum_ext[DATA_W-1:0];
                flag_bit = sum_ext[DATA_W];
            end
            OP_SUB: begin
                result   = opa - opb;
                flag_bit = (opa > opb);
            end
            OP_RSUB: begin
                result   = opb - opa;
                flag_bit = (opb > opa);
            end
            OP_SHR: begin
                result   = {1'b0, opa[DATA_W-1:1]};
                flag_bit = opa[0];
            end
            OP_SHL: begin
                result   = {opa[DATA_W-2:0], 1'b0};
                flag_bit = opa[DATA_W-1];
            end
            default: begin
                result   = '0;
                flag_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_regfile.sv
`timescale 1ns/1ps
module alu8_regfile
    import alu8_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 16,
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int FLAG_IDX = REG_COUNT - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    input  logic [IDX_W-1:0]  dbg_rd_idx,
    input  logic              res_we,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [DATA_W-1:0] res_data,
    input  logic              flag_we,
    input  logic              flag_data,
    input  wr_order_e         order,
    input  logic              dbg_we,
    input  logic [IDX_W-1:0]  dbg_widx,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    output logic [DATA_W-1:0] dbg_rd,
    output logic [DATA_W-1:0] flag_q
);

    logic [DATA_W-1:0] regs_q [REG_COUNT];
    logic [DATA_W-1:0] flag_word;

    assign flag_word = {{(DATA_W-1){1'b0}}, flag_data};

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic hit_res;
        logic hit_flag;
        logic hit_dbg;

        assign hit_res  = res_we && (res_idx == IDX_W'(g));
        assign hit_flag = flag_we && (g == FLAG_IDX);
        assign hit_dbg  = dbg_we && (dbg_widx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (hit_res && hit_flag) begin
                regs_q[g] <= (order == FLAG_LAST) ? flag_word : res_data;
            end else if (hit_res) begin
                regs_q[g] <= res_data;
            end else if (hit_flag) begin
                regs_q[g] <= flag_word;
            end else if (hit_dbg) begin
                regs_q[g] <= dbg_wdata;
            end
        end
    end

    assign rd_a   = regs_q[rd_a_idx];
    assign rd_b   = regs_q[rd_b_idx];
    assign dbg_rd = regs_q[dbg_rd_idx];
    assign flag_q = regs_q[FLAG_IDX];

endmodule

// File: rtl/alu8_seq.sv
`timescale 1ns/1ps
module alu8_seq (
    input  logic clk,
    input  logic rst,
    input  logic op_en,
    input  logic illegal,
    output logic done_q,
    output logic err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= op_en;
            err_q  <= err_q | (op_en & illegal);
        end
    end

endmodule

// File: rtl/alu8_vm_alu.sv
`timescale 1ns/1ps
module alu8_vm_alu
    import alu8_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 16,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_en,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [IDX_W-1:0]  idx_x,
    input  logic [IDX_W-1:0]  idx_y,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              err
);

    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_flag;
    alu_ctl_t          alu_ctl;
    logic [DATA_W-1:0] flag_val;
    logic              res_we_g;
    logic              flag_we_g;
    logic              dbg_we_g;

    assign res_we_g  = op_en & alu_ctl.res_we;
    assign flag_we_g = op_en & alu_ctl.flag_we;
    assign dbg_we_g  = wr_en & ~op_en;

    alu8_regfile #(
        .DATA_W    (DATA_W),
        .REG_COUNT (REG_COUNT)
    ) u_rf (
        .clk        (clk),
        .rst        (rst),
        .rd_a_idx   (idx_x),
        .rd_b_idx   (idx_y),
        .dbg_rd_idx (rd_idx),
        .res_we     (res_we_g),
        .res_idx    (idx_x),
        .res_data   (alu_res),
        .flag_we    (flag_we_g),
        .flag_data  (alu_flag),
        .order      (alu_ctl.order),
        .dbg_we     (dbg_we_g),
        .dbg_widx   (wr_idx),
        .dbg_wdata  (wr_data),
        .rd_a       (opnd_a),
        .rd_b       (opnd_b),
        .dbg_rd     (rd_data),
        .flag_q     (flag_val)
    );

    alu8_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .op_code  (op_code),
        .opa      (opnd_a),
        .opb      (opnd_b),
        .result   (alu_res),
        .flag_bit (alu_flag),
        .ctl      (alu_ctl)
    );

    alu8_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .op_en   (op_en),
        .illegal (alu_ctl.illegal),
        .done_q  (done),
        .err_q   (err)
    );

endmodule

// File: rtl/alu8_vm_alu_chk.sv
`timescale 1ns/1ps
module alu8_vm_alu_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int REG_COUNT = 16,
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int FLAG_IDX = REG_COUNT - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              op_en,
    input logic [OPC_W-1:0]  op_code,
    input logic [IDX_W-1:0]  idx_x,
    input logic              wr_en,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] flag_val,
    input logic              done,
    input logic              err
);

    logic [DATA_W:0] ref_sum;
    logic            x_is_flag;
    logic            logic_group;

    assign ref_sum     = {1'b0, opnd_a} + {1'b0, opnd_b};
    assign x_is_flag   = (idx_x == IDX_W'(FLAG_IDX));
    assign logic_group = (op_code == OP_MOVE) || (op_code == OP_OR) ||
                         (op_code == OP_AND)  || (op_code == OP_XOR);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !err));

    assert_done_follows_en_R8: assert property (@(posedge clk) disable iff (rst)
        op_en |=> done);

    assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> !done);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_illegal_sets_err_R7: assert property (@(posedge clk) disable iff (rst)
        (op_en && !op_is_legal(op_code)) |=> err);

    assert_illegal_keeps_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (op_en && !op_is_legal(op_code) && !wr_en) |=> $stable(flag_val));

    assert_logic_keeps_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (op_en && logic_group && !x_is_flag && !wr_en) |=> $stable(flag_val));

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_ADD) |=>
            (flag_val == {{(DATA_W-1){1'b0}}, $past(ref_sum[DATA_W])}));

    assert_sub_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (op_en && op_code == OP_SUB && !x_is_flag) |=>
            (flag_val == {{(DATA_W-1){1'b0}}, $past(opnd_a > opnd_b)}));

endmodule

bind alu8_vm_alu alu8_vm_alu_chk #(
    .DATA_W    (DATA_W),
    .REG_COUNT (REG_COUNT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_en    (op_en),
    .op_code  (op_code),
    .idx_x    (idx_x),
    .wr_en    (wr_en),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .flag_val (flag_val),
    .done     (done),
    .err      (err)
);

// File: tb/test_alu8_vm_alu.sv
`timescale 1ns/100ps
module test_alu8_vm_alu;

    typedef struct {
        int         idx;   // -1 selects the error output
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_en = 1'b0;
    logic [3:0] op_code = '0;
    logic [3:0] idx_x = '0;
    logic [3:0] idx_y = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_idx;
    logic [7:0] rd_data;
    logic       done;
    logic       err;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   reset_checked = 1'b0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    logic [7:0] m [16];
    logic       m_err = 1'b0;

    always #4 clk = ~clk;

    alu8_vm_alu i_alu8_vm_alu (
        .clk     (clk),
        .rst     (rst),
        .op_en   (op_en),
        .op_code (op_code),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .done    (done),
        .err     (err)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic dbg_load(int idx, logic [7:0] val);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = idx[3:0];
        wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        m[idx] = val;
    endtask

    // Driver: model the operation, push expectations, then apply it
    task automatic run_op(logic [3:0] code, int x, int y, string tag,
                          bit with_wr = 1'b0, int widx = 0, logic [7:0] wval = 8'h00);
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] res;
        logic       flg;
        bit         has_flag;
        bit         flag_last;
        bit         bad;
        a = m[x];
        b = m[y];
        res = 8'h00; flg = 1'b0; has_flag = 0; flag_last = 1; bad = 0;
        case (code)
            4'h0: res = b;
            4'h1: res = a | b;
            4'h2: res = a & b;
            4'h3: res = a ^ b;
            4'h4: begin res = a + b; flg = ((a + 9'd0) + b) > 9'd255; has_flag = 1; end
            4'h5: begin res = a - b; flg = a > b; has_flag = 1; flag_last = 0; end
            4'h7: begin res = b - a; flg = b > a; has_flag = 1; flag_last = 0; end
            4'h6: begin res = a >> 1; flg = a[0]; has_flag = 1; end
            4'hE: begin res = a << 1; flg = a[7]; has_flag = 1; end
            default: bad = 1;
        endcase
        if (bad) begin
            m_err = 1'b1;
        end else begin
            m[x] = res;
            if (has_flag && (x != 15 || flag_last)) m[15] = {7'd0, flg};
        end
        sb_q.push_back('{x, m[x], tag});
        sb_q.push_back('{15, m[15], tag});
        if (y != x && y != 15) sb_q.push_back('{y, m[y], tag});
        sb_q.push_back('{-1, {7'd0, m_err}, bad ? "R7" : tag});
        if (with_wr) sb_q.push_back('{widx, m[widx], "R9"});
        @(negedge clk);
        op_en   = 1'b1;
        op_code = code;
        idx_x   = x[3:0];
        idx_y   = y[3:0];
        wr_en   = with_wr;
        wr_idx  = widx[3:0];
        wr_data = wval;
        @(negedge clk);
        op_en = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle only", done, 0);
        @(negedge clk);
    endtask

    // Monitor: on each done strobe, pop and compare the expectations
    initial begin
        exp_t it;
        rd_idx = '0;
        @(negedge clk);
        while (rst) @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(err == 1'b0, "R1", "err after reset", err, 0);
        for (int i = 0; i < 16; i++) begin
            rd_idx = i[3:0];
            #0.2;
            check(rd_data == 8'h00, "R1", "reg after reset", rd_data, 0);
        end
        reset_checked = 1'b1;
        forever begin
            @(negedge clk);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "done with nothing pending", 1, 0);
                end
                while (sb_q.size() > 0) begin
                    it = sb_q.pop_front();
                    if (it.idx < 0) begin
                        check(err == it.val[0], it.tag, "err", err, it.val[0]);
                    end else begin
                        rd_idx = it.idx[3:0];
                        #0.3;
                        check(rd_data == it.val, it.tag, $sformatf("reg %0d", it.idx),
                              rd_data, it.val);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait (reset_checked);

        // R9: debug loads, R2: logic group keeps flag
        dbg_load(1, 8'h3C);
        dbg_load(2, 8'hA5);
        dbg_load(15, 8'h77);
        run_op(4'h0, 3, 2, "R2");
        run_op(4'h1, 1, 2, "R2");
        run_op(4'h2, 3, 1, "R2");
        run_op(4'h3, 2, 1, "R2");

        // R3: add with and without carry, flag as operand, x is flag
        dbg_load(4, 8'hF0);
        dbg_load(5, 8'h20);
        run_op(4'h4, 4, 5, "R3");
        dbg_load(4, 8'h10);
        run_op(4'h4, 4, 5, "R3");
        run_op(4'h4, 5, 15, "R3");
        dbg_load(15, 8'h05);
        dbg_load(6, 8'h03);
        run_op(4'h4, 15, 6, "R3");

        // R4: subtract greater, equal, wrap, x is flag
        dbg_load(7, 8'h50);
        dbg_load(8, 8'h30);
        run_op(4'h5, 7, 8, "R4");
        dbg_load(7, 8'h30);
        run_op(4'h5, 7, 8, "R4");
        dbg_load(7, 8'h10);
        run_op(4'h5, 7, 8, "R4");
        dbg_load(15, 8'h09);
        dbg_load(9, 8'h04);
        run_op(4'h5, 15, 9, "R4");

        // R5: reverse subtract
        dbg_load(7, 8'h20);
        dbg_load(8, 8'h60);
        run_op(4'h7, 7, 8, "R5");
        dbg_load(7, 8'h60);
        run_op(4'h7, 7, 8, "R5");
        dbg_load(7, 8'h61);
        run_op(4'h7, 7, 8, "R5");
        dbg_load(15, 8'h02);
        dbg_load(9, 8'h09);
        run_op(4'h7, 15, 9, "R5");

        // R6: shifts, Vy irrelevant, x is flag
        dbg_load(10, 8'h81);
        dbg_load(11, 8'hFF);
        run_op(4'h6, 10, 11, "R6");
        dbg_load(10, 8'h81);
        run_op(4'hE, 10, 1, "R6");
        dbg_load(10, 8'h40);
        run_op(4'hE, 10, 11, "R6");
        dbg_load(10, 8'h40);
        run_op(4'hE, 10, 2, "R6");
        dbg_load(15, 8'h81);
        run_op(4'h6, 15, 2, "R6");

        // R7: illegal codes, sticky error
        dbg_load(12, 8'h5A);
        dbg_load(13, 8'hC3);
        dbg_load(15, 8'h44);
        run_op(4'h8, 12, 13, "R7");
        run_op(4'hF, 15, 13, "R7");
        run_op(4'h1, 12, 13, "R7");

        // R9: debug write ignored during an operation
        run_op(4'h0, 2, 13, "R9", 1'b1, 3, 8'hEE);

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R8", "pending expectations", sb_q.size(), 0);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule